// File: doc/BRIEF.md
# Fan Speed Sequencer with Kick-Start

This block drives the four active-low, open-drain control lines of a fan: three speed lines and one shutdown line. Each output is a pull-down enable, where 1 means the pad pulls its line low and 0 means it releases the line. A 3-bit speed register selects the running speed. Value 0 means off, 1 is the slowest speed and 7 the fastest. In the running state the three speed lines carry the inverse of the speed, so their pull-down enables equal the speed value, and the shutdown line is released.

A fan that starts from rest at a low speed may stall, so the block always starts it at full speed. When the speed register goes from zero to a nonzero value, the speed lines first show full speed. Half of a start interval later the shutdown line is released. Once the whole start interval has passed, the lines settle at the programmed speed. Shutdown runs in the reverse order: the shutdown line is asserted first, and the speed lines are released half an interval later. All intervals are counted in ticks of a slow timebase. A run flag is high only while a timed sequence is in progress, so the interval oscillator can be stopped at all other times.

When fan mode is disabled, all four pull-down enables are 0 and the pins belong to other logic. All pins are plain control signals, so there is no handshake and no back-pressure. A speed write is taken in the clock cycle its strobe is high.

Top module: `fan_kick_seq`

## Requirements
- R1: After reset the speed register is 0 and no sequence runs. With fan mode on, `pd_en` is 4'b0001 (the shutdown line is pulled low and the speed lines are released) and `osc_run` is 0. With fan mode off, `pd_en` is 4'b0000.
- R2: While `fan_en` is 0, `pd_en` is 4'b0000. One cycle after `fan_en` falls, `osc_run` is 0 and any sequence is abandoned. Raising `fan_en` while the speed register is nonzero starts a kick.
- R3: In the running state with speed D (nonzero), `pd_en[3:1]` equals D, `pd_en[0]` is 0, and `osc_run` is 0.
- R4: A nonzero write while the register holds 0 sets `pd_en[3:1]` to 3'b111 one cycle after the write is taken, and keeps it there for T_START ticks. The programmed speed appears on the edge of the T_START-th tick.
- R5: During a kick, `pd_en[0]` stays 1 for the first T_START/2 ticks and goes to 0 on the edge of the (T_START/2)-th tick.
- R6: A zero write while the fan is running sets `pd_en[0]` to 1 one cycle after the write is taken, with `pd_en[3:1]` unchanged. After T_START/2 ticks, `pd_en[3:1]` becomes 3'b000.
- R7: `osc_run` is 1 exactly while a kick or a shutdown sequence is in progress. Ticks have no effect in the off or running state.
- R8: A nonzero write during a kick changes the target speed without restarting the interval. The kick still ends T_START ticks after it began, at the new speed.
- R9: A zero write during a kick ends the kick at once and starts the shutdown sequence. The speed lines stay at 3'b111 for T_START/2 ticks and are then released.
- R10: A nonzero write during a shutdown sequence starts a new kick from its beginning.
- R11: A nonzero write while the fan is running changes `pd_en[3:1]` to the new value one cycle after the write is taken, with no kick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fan_en | input | 1 | Fan mode enable; when 0 the outputs release the pins |
| spd_wr | input | 1 | Write strobe for the speed register |
| spd_wdata | input | 3 | Speed value written when `spd_wr` is 1 |
| tick | input | 1 | One-cycle pulse from the slow timebase |
| pd_en | output | 4 | Pull-down enables: [3:1] for the speed lines (bit 3 = most significant), [0] for shutdown |
| osc_run | output | 1 | High while a timed interval is in progress |

## Verification
The assertions check the ordering rules on every cycle. Released shutdown is only ever seen with the speed lines at full. Every start from rest begins at full speed with shutdown still asserted. Every assertion of shutdown leaves the speed lines untouched in that cycle. The run flag only drops into the off or running state. The exact tick counts cannot be judged by a per-cycle property: T_START, its half, no restart on a target update, abort during a kick, and restart during shutdown. Only the bench's ordered write and tick scenarios show these.

// File: rtl/fan_seq_pkg.sv
package fan_seq_pkg;
  localparam int SPD_W = 3;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_KICK_LO,   // full speed, shutdown still asserted
    ST_KICK_HI,   // full speed, shutdown released
    ST_RUN,
    ST_STOP       // shutdown asserted, speed lines held
  } seq_state_e;
endpackage

// File: rtl/fan_speed_reg.sv
module fan_speed_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] spd,
  output logic         spd_nz
);
  always_ff @(posedge clk) begin
    if (!rst_n)   spd <= '0;
    else if (wr)  spd <= wdata;
  end

  assign spd_nz = |spd;
endmodule

// File: rtl/fan_interval_timer.sv
module fan_interval_timer #(
  parameter int T_START = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  input  logic use_half,
  output logic done
);
  localparam int HALF = T_START / 2;
  localparam int CW   = $clog2(T_START + 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
  localparam logic [CW-1:0] REST_LAST = CW'(T_START - HALF - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = use_half ? HALF_LAST : REST_LAST;
  assign done = run && tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)     cnt <= '0;
    else if (run && tick)  cnt <= done ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/fan_seq_fsm.sv
module fan_seq_fsm
  import fan_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fan_en,
  input  logic [SPD_W-1:0] spd,
  input  logic             spd_nz,
  input  logic             done,
  output logic [SPD_W-1:0] fs_pd,
  output logic             shdn_pd,
  output logic             osc_run,
  output logic             tmr_clr,
  output logic             use_half
);
  seq_state_e       st, nxt;
  logic [SPD_W-1:0] fs_nxt;
  logic             shdn_nxt;

  always_comb begin
    nxt      = st;
    fs_nxt   = fs_pd;
    shdn_nxt = shdn_pd;
    case (st)
      ST_OFF: begin
        fs_nxt   = '0;
        shdn_nxt = 1'b1;
        if (fan_en && spd_nz) begin
          nxt    = ST_KICK_LO;
          fs_nxt = '1;
        end
      end
      ST_KICK_LO, ST_KICK_HI: begin
        if (!fan_en) begin
          nxt = ST_OFF; fs_nxt = '0; shdn_nxt = 1'b1;
        end else if (!spd_nz) begin
          nxt = ST_STOP; shdn_nxt = 1'b1;
        end else if (done && st == ST_KICK_LO) begin
          nxt = ST_KICK_HI; shdn_nxt = 1'b0;
        end else if (done) begin
          nxt = ST_RUN; fs_nxt = spd;
        end
      end
      ST_RUN: begin
        if (!fan_en) begin
          nxt = ST_OFF; fs_nxt = '0; shdn_nxt = 1'b1;
        end else if (!spd_nz) begin
          nxt = ST_STOP; shdn_nxt = 1'b1;
        end else begin
          fs_nxt = spd;
        end
      end
      ST_STOP: begin
        if (!fan_en) begin
          nxt = ST_OFF; fs_nxt = '0;
        end else if (spd_nz) begin
          nxt = ST_KICK_LO; fs_nxt = '1;
        end else if (done) begin
          nxt = ST_OFF; fs_nxt = '0;
        end
      end
      default: begin
        nxt = ST_OFF; fs_nxt = '0; shdn_nxt = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      fs_pd   <= '0;
      shdn_pd <= 1'b1;
    end else begin
      st      <= nxt;
      fs_pd   <= fs_nxt;
      shdn_pd <= shdn_nxt;
    end
  end

  assign osc_run  = (st == ST_KICK_LO) || (st == ST_KICK_HI) || (st == ST_STOP);
  assign tmr_clr  = (nxt != st);
  assign use_half = (st != ST_KICK_HI);
endmodule

// File: rtl/fan_pin_enc.sv
module fan_pin_enc #(
  parameter int W = 3
) (
  input  logic         fan_en,
  input  logic [W-1:0] fs_pd,
  input  logic         shdn_pd,
  output logic [W:0]   pd_en
);
  assign pd_en = fan_en ? {fs_pd, shdn_pd} : '0;
endmodule

// File: rtl/fan_kick_seq.sv
module fan_kick_seq
  import fan_seq_pkg::*;
#(
  parameter int T_START = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fan_en,
  input  logic             spd_wr,
  input  logic [SPD_W-1:0] spd_wdata,
  input  logic             tick,
  output logic [SPD_W:0]   pd_en,
  output logic             osc_run
);
  logic [SPD_W-1:0] spd, fs_pd;
  logic             spd_nz, done, shdn_pd, tmr_clr, use_half;

  fan_speed_reg #(.W(SPD_W)) u_spd (
    .clk(clk), .rst_n(rst_n), .wr(spd_wr), .wdata(spd_wdata),
    .spd(spd), .spd_nz(spd_nz)
  );

  fan_interval_timer #(.T_START(T_START)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(osc_run),
    .tick(tick), .use_half(use_half), .done(done)
  );

  fan_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fan_en(fan_en), .spd(spd), .spd_nz(spd_nz),
    .done(done), .fs_pd(fs_pd), .shdn_pd(shdn_pd), .osc_run(osc_run),
    .tmr_clr(tmr_clr), .use_half(use_half)
  );

  fan_pin_enc #(.W(SPD_W)) u_enc (
    .fan_en(fan_en), .fs_pd(fs_pd), .shdn_pd(shdn_pd), .pd_en(pd_en)
  );
endmodule

// File: rtl/fan_kick_seq_chk.sv
module fan_kick_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fan_en,
  input logic [3:0] pd_en,
  input logic       osc_run
);
  // R2
  en_off_stops_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fan_en |=> !osc_run);

  // R5
  shdn_release_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pd_en[0]) && fan_en) |-> (pd_en[3:1] == 3'b111));

  // R4
  start_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|pd_en[3:1]) && fan_en && $past(fan_en)) |-> (pd_en == 4'b1111));

  // R6
  shdn_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pd_en[0]) && fan_en && $past(fan_en)) |-> (pd_en[3:1] == $past(pd_en[3:1])));

  // R7
  osc_end_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(osc_run) && fan_en && $past(fan_en)) |->
      ((pd_en == 4'b0001) || (!pd_en[0] && (pd_en[3:1] != 3'b000))));

  // R3
  released_means_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fan_en && !osc_run && !pd_en[0]) |-> (pd_en[3:1] != 3'b000));
endmodule

bind fan_kick_seq fan_kick_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fan_en(fan_en), .pd_en(pd_en), .osc_run(osc_run)
);

// File: tb/fan_kick_seq_bench.sv
module fan_kick_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fan_en = 1'b0;
  logic       spd_wr = 1'b0;
  logic [2:0] spd_wdata = 3'd0;
  logic       tick = 1'b0;
  logic [3:0] pd_en;
  logic       osc_run;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fan_kick_seq #(.T_START(TS)) u_fan_kick_seq (
    .clk(clk), .rst_n(rst_n), .fan_en(fan_en), .spd_wr(spd_wr),
    .spd_wdata(spd_wdata), .tick(tick), .pd_en(pd_en), .osc_run(osc_run)
  );

  // row: {wr, data[2:0], ticks[3:0], exp_pd[3:0], exp_osc, req[3:0]}
  localparam int NV = 23;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 3'd3, 4'd0, 4'b1111, 1'b1, 4'd4},  // R4 kick begins at full
    {1'b0, 3'd0, 4'd3, 4'b1111, 1'b1, 4'd5},  // R5 shutdown still held
    {1'b0, 3'd0, 4'd1, 4'b1110, 1'b1, 4'd5},  // R5 released at half
    {1'b0, 3'd0, 4'd3, 4'b1110, 1'b1, 4'd4},  // R4 still full
    {1'b0, 3'd0, 4'd1, 4'b0110, 1'b0, 4'd3},  // R3 settle at speed 3
    {1'b1, 3'd5, 4'd0, 4'b1010, 1'b0, 4'd11}, // R11 change while running
    {1'b1, 3'd0, 4'd0, 4'b1011, 1'b1, 4'd6},  // R6 shutdown first
    {1'b0, 3'd0, 4'd3, 4'b1011, 1'b1, 4'd6},  // R6 speed lines held
    {1'b0, 3'd0, 4'd1, 4'b0001, 1'b0, 4'd6},  // R6 released after half
    {1'b1, 3'd1, 4'd0, 4'b1111, 1'b1, 4'd4},  // R4 second kick
    {1'b0, 3'd0, 4'd2, 4'b1111, 1'b1, 4'd4},
    {1'b1, 3'd6, 4'd0, 4'b1111, 1'b1, 4'd8},  // R8 target update mid kick
    {1'b0, 3'd0, 4'd2, 4'b1110, 1'b1, 4'd8},  // R8 no restart
    {1'b0, 3'd0, 4'd4, 4'b1100, 1'b0, 4'd8},  // R8 new target applied
    {1'b1, 3'd0, 4'd0, 4'b1101, 1'b1, 4'd6},
    {1'b0, 3'd0, 4'd2, 4'b1101, 1'b1, 4'd6},
    {1'b1, 3'd2, 4'd0, 4'b1111, 1'b1, 4'd10}, // R10 restart during stop
    {1'b0, 3'd0, 4'd4, 4'b1110, 1'b1, 4'd10}, // R10 full half again
    {1'b1, 3'd0, 4'd0, 4'b1111, 1'b1, 4'd9},  // R9 abort in second half
    {1'b0, 3'd0, 4'd4, 4'b0001, 1'b0, 4'd9},
    {1'b1, 3'd7, 4'd1, 4'b1111, 1'b1, 4'd4},
    {1'b1, 3'd0, 4'd3, 4'b1111, 1'b1, 4'd9},  // R9 abort in first half
    {1'b0, 3'd0, 4'd1, 4'b0001, 1'b0, 4'd9}
  };

  task automatic check(input logic [3:0] exp_pd, input logic exp_osc, input int req);
    checks++;
    if (pd_en !== exp_pd || osc_run !== exp_osc) begin
      errors++;
      $display("FAIL R%0d: pd_en=%b osc_run=%b expected pd_en=%b osc_run=%b",
               req, pd_en, osc_run, exp_pd, exp_osc);
    end
  endtask

  task automatic step(input logic wr, input logic [2:0] d, input int nt);
    @(negedge clk); spd_wr = wr; spd_wdata = d;
    @(negedge clk); spd_wr = 1'b0;
    @(negedge clk);
    for (int i = 0; i < nt; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(4'b0000, 1'b0, 1);  // R1 fan mode off after reset
    fan_en = 1'b1;
    @(negedge clk);
    check(4'b0001, 1'b0, 1);  // R1 off state pins
    step(1'b0, 3'd0, 3);
    check(4'b0001, 1'b0, 7);  // R7 ticks ignored when off

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][16], VEC[v][15:13], int'(VEC[v][12:9]));
      check(VEC[v][8:5], VEC[v][4], int'(VEC[v][3:0]));
    end

    // reach running state at speed 4
    step(1'b1, 3'd4, TS);
    check(4'b1000, 1'b0, 3);  // R3
    step(1'b0, 3'd0, 3);
    check(4'b1000, 1'b0, 7);  // R7 ticks ignored when running

    // R2 fan mode off releases pins and stops sequences
    @(negedge clk); fan_en = 1'b0;
    @(negedge clk);
    check(4'b0000, 1'b0, 2);
    @(negedge clk); fan_en = 1'b1;
    @(negedge clk);
    check(4'b1111, 1'b1, 2);  // R2 re-enable kicks again
    fan_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(4'b0000, 1'b0, 2);  // R2 kick abandoned

    // R1 reset clears the speed register
    fan_en = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 3'd0, 2);
    check(4'b0001, 1'b0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule